// File: doc/BRIEF.md
# DDR4 Mode-Register Pair Sequencer

This block turns one request to program a DDR4 mode register into the command pair that a registered memory module expects. The request carries a register number, the opcode bits, a target rank and an idle count. From these the block assembles the A-side address word. It swaps selected address and bank bits when the target rank is odd and mirroring is enabled. It then derives the B-side word by inverting a fixed set of bits. The two commands leave on a valid/ready command port, A-side first, and each one is followed by its own run of idle cycles.

Three request kinds set one MR3 multipurpose-register field over a base opcode: the MPR enable bit, the read format or the page. For these kinds the register number is forced to 3 and the idle count is forced to the tMRD parameter. A field value outside its legal range is refused with a one-cycle error pulse, and no command is sent.

Top module: `mrs_pair_seq`

## Requirements
- R1: Every accepted request that passes its check produces exactly two commands on the command port. The first carries `cmd_side`=0 (A-side) and the second `cmd_side`=1 (B-side). No request is accepted while commands are pending (`req_ready` is low whenever `cmd_valid` is high).
- R2: The A-side word without mirroring has this layout: opcode bits A0–A13 in word bits 0–13 and A14–A17 in word bits 20–23. Register-number bits 0, 1 and 2 go to bit 17 (BA0), bit 18 (BA1) and bit 19 (BG0). Bit 15 (BG1) and bits 14 and 16 are zero.
- R3: The B-side word equals the A-side word with word bits 3–9, 11, 13, 23, 17, 18, 19 and 15 inverted; all other bits are equal.
- R4: With `mirror_en`=1 and rank bit 0 = 1, the A-side word has these pairs of bit positions exchanged: 3/4, 5/6, 7/8, 11/13, 17/18 and 19/15. Otherwise no bit is exchanged. The B-side word is derived from the mirrored A-side word.
- R5: After the A-side handshake, `cmd_valid` stays low for exactly the idle count before the B-side command appears. After the B-side handshake, `req_ready` stays low for exactly the idle count. An idle count of 0 gives back-to-back commands.
- R6: Request kind 1 writes field bit 0 into A2, kind 2 writes field bits 1:0 into A12:A11, and kind 3 writes field bits 1:0 into A1:A0. All other opcode bits come from `req_opcode`. For these kinds the register number is 3 and the idle count is the TMRD parameter, whatever `req_idle` and `req_mr` carry.
- R7: A kind-1 field above 1, a kind-2 field above 2 or a kind-3 field above 3 is rejected. In that case `err` is high for the single cycle after acceptance, no command is issued and `req_ready` stays high. Kind 0 never checks `req_field`.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command port holds `cmd_valid`, `cmd_addr`, `cmd_side` and `cmd_cs_n` unchanged.
- R9: While a command is valid, `cmd_cs_n` drives bit *rank* low and all other bits high, and `cmd_rcw_n` is 3'b000. Both sides of a pair carry the same chip-select. With no command valid, all bits of both are high.
- R10: After reset `req_ready`=1, `cmd_valid`=0, `err`=0 and `cmd_cs_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mirror_en | input | 1 | Enables address mirroring for odd ranks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 raw write, 1 MPR enable, 2 MPR read format, 3 MPR page |
| req_mr | input | 3 | Mode register number (kind 0) |
| req_opcode | input | 18 | Opcode bits A0–A17 |
| req_field | input | 3 | MR3 field value for kinds 1–3 |
| req_rank | input | RANK_W | Target rank |
| req_idle | input | IDLE_W | Idle cycles after each command (kind 0) |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command taken by the downstream stage |
| cmd_side | output | 1 | 0 A-side, 1 B-side |
| cmd_addr | output | 24 | Address/bank word |
| cmd_cs_n | output | NRANK | Active-low chip selects |
| cmd_rcw_n | output | 3 | Active-low RAS/CAS/WE command bits |
| err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The vector walk uses raw opcodes of all zeros and all ones, together with sparse patterns. This shows whether the mirror swaps and the side-B inversions act on the right bit positions. Odd ranks with mirroring disabled and even ranks with mirroring enabled are each tried, so a rank or enable condition that is too loose cannot pass. Each MR3 kind is sent with its highest legal value and its lowest illegal value, and the checks include the forced register number and the forced idle count. Idle counts of 0, 1 and several cycles, plus a backpressured command, show that the idle counter and the hold on the command port are exact.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

  localparam int ADDR_W   = 24;
  localparam int OPC_W    = 18;
  localparam int MR_W     = 3;
  localparam int FIELD_W  = 3;

  // word positions decoded by the downstream command stage
  localparam int POS_HI_BASE = 20;   // A14..A17
  localparam int POS_BA0     = 17;
  localparam int POS_BA1     = 18;
  localparam int POS_BG0     = 19;
  localparam int POS_BG1     = 15;
  localparam int POS_A17     = 23;

  localparam int NPAIR = 6;
  localparam int SWAP_LO [NPAIR] = '{3, 5, 7, 11, POS_BA0, POS_BG0};
  localparam int SWAP_HI [NPAIR] = '{4, 6, 8, 13, POS_BA1, POS_BG1};

  typedef enum logic [1:0] {
    KIND_RAW      = 2'd0,
    KIND_MPR_EN   = 2'd1,
    KIND_MPR_FMT  = 2'd2,
    KIND_MPR_PAGE = 2'd3
  } req_kind_e;

  localparam logic [FIELD_W-1:0] LIM_MPR_EN   = 3'd1;
  localparam logic [FIELD_W-1:0] LIM_MPR_FMT  = 3'd2;
  localparam logic [FIELD_W-1:0] LIM_MPR_PAGE = 3'd3;
  localparam logic [MR_W-1:0]    MR_MPR       = 3'd3;

  function automatic logic [ADDR_W-1:0] side_b_mask();
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 3; i <= 9; i++) m[i] = 1'b1;
    m[11]      = 1'b1;
    m[13]      = 1'b1;
    m[POS_A17] = 1'b1;
    m[POS_BA0] = 1'b1;
    m[POS_BA1] = 1'b1;
    m[POS_BG0] = 1'b1;
    m[POS_BG1] = 1'b1;
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] INV_MASK = side_b_mask();

  function automatic logic [ADDR_W-1:0] pack_word(input logic [MR_W-1:0] mr,
                                                  input logic [OPC_W-1:0] opc);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[13:0] = opc[13:0];
    w[POS_HI_BASE +: 4] = opc[17:14];
    w[POS_BA0] = mr[0];
    w[POS_BA1] = mr[1];
    w[POS_BG0] = mr[2];
    return w;
  endfunction

endpackage

// File: rtl/mrs_req_check.sv
module mrs_req_check
  import mrs_seq_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int TMRD   = 8
) (
  input  logic [1:0]         kind,
  input  logic [MR_W-1:0]    mr_in,
  input  logic [OPC_W-1:0]   opc_in,
  input  logic [FIELD_W-1:0] field,
  input  logic [IDLE_W-1:0]  idle_in,
  output logic               bad,
  output logic [MR_W-1:0]    mr_out,
  output logic [OPC_W-1:0]   opc_out,
  output logic [IDLE_W-1:0]  idle_out
);

  localparam logic [IDLE_W-1:0] TMRD_CYC = IDLE_W'(TMRD);

  always_comb begin
    bad      = 1'b0;
    mr_out   = mr_in;
    opc_out  = opc_in;
    idle_out = idle_in;
    unique case (req_kind_e'(kind))
      KIND_MPR_EN: begin
        bad        = (field > LIM_MPR_EN);
        opc_out[2] = field[0];
        mr_out     = MR_MPR;
        idle_out   = TMRD_CYC;
      end
      KIND_MPR_FMT: begin
        bad            = (field > LIM_MPR_FMT);
        opc_out[12:11] = field[1:0];
        mr_out         = MR_MPR;
        idle_out       = TMRD_CYC;
      end
      KIND_MPR_PAGE: begin
        bad          = (field > LIM_MPR_PAGE);
        opc_out[1:0] = field[1:0];
        mr_out       = MR_MPR;
        idle_out     = TMRD_CYC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mrs_addr_mirror.sv
module mrs_addr_mirror
  import mrs_seq_pkg::*;
(
  input  logic              swap_en,
  input  logic [ADDR_W-1:0] word_in,
  output logic [ADDR_W-1:0] word_out
);

  logic [ADDR_W-1:0] swapped;

  always_comb begin
    swapped = word_in;
    for (int k = 0; k < NPAIR; k++) begin
      swapped[SWAP_LO[k]] = word_in[SWAP_HI[k]];
      swapped[SWAP_HI[k]] = word_in[SWAP_LO[k]];
    end
  end

  assign word_out = swap_en ? swapped : word_in;

endmodule

// File: rtl/mrs_issue_fsm.sv
module mrs_issue_fsm
  import mrs_seq_pkg::*;
#(
  parameter int NRANK  = 4,
  parameter int RANK_W = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] a_word,
  input  logic [RANK_W-1:0] rank,
  input  logic [IDLE_W-1:0] idle,
  input  logic              cmd_ready,
  output logic              is_idle,
  output logic              cmd_valid,
  output logic              cmd_side,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NRANK-1:0]  cmd_cs_n,
  output logic [2:0]        cmd_rcw_n
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND_A = 3'd1,
    ST_GAP_A = 3'd2,
    ST_SEND_B = 3'd3,
    ST_GAP_B = 3'd4
  } st_e;

  st_e               state_q, state_d;
  logic [ADDR_W-1:0] word_q;
  logic [RANK_W-1:0] rank_q;
  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic              load_en, cnt_en, sent;
  logic              idle_zero, cnt_last;

  assign sent      = cmd_valid && cmd_ready;
  assign idle_zero = (idle_q == '0);
  assign cnt_last  = (cnt_q == IDLE_W'(1));
  assign load_en   = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_SEND_A;
      ST_SEND_A: if (sent) begin
        state_d = idle_zero ? ST_SEND_B : ST_GAP_A;
        cnt_d   = idle_q;
        cnt_en  = 1'b1;
      end
      ST_GAP_A: begin
        if (cnt_last) state_d = ST_SEND_B;
        cnt_d  = cnt_q - IDLE_W'(1);
        cnt_en = 1'b1;
      end
      ST_SEND_B: if (sent) begin
        state_d = idle_zero ? ST_IDLE : ST_GAP_B;
        cnt_d   = idle_q;
        cnt_en  = 1'b1;
      end
      ST_GAP_B: begin
        if (cnt_last) state_d = ST_IDLE;
        cnt_d  = cnt_q - IDLE_W'(1);
        cnt_en = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rank_q <= '0;
      idle_q <= '0;
    end else if (load_en) begin
      word_q <= a_word;
      rank_q <= rank;
      idle_q <= idle;
    end
  end

  assign is_idle   = (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_SEND_A) || (state_q == ST_SEND_B);
  assign cmd_side  = (state_q == ST_SEND_B);
  assign cmd_addr  = cmd_side ? (word_q ^ INV_MASK) : word_q;
  assign cmd_rcw_n = cmd_valid ? 3'b000 : 3'b111;

  for (genvar r = 0; r < NRANK; r++) begin : g_cs
    assign cmd_cs_n[r] = !(cmd_valid && (rank_q == RANK_W'(r)));
  end

endmodule

// File: rtl/mrs_pair_seq.sv
module mrs_pair_seq
  import mrs_seq_pkg::*;
#(
  parameter int NRANK  = 4,
  parameter int IDLE_W = 8,
  parameter int TMRD   = 8,
  localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mirror_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_kind,
  input  logic [MR_W-1:0]         req_mr,
  input  logic [OPC_W-1:0]        req_opcode,
  input  logic [FIELD_W-1:0]      req_field,
  input  logic [RANK_W-1:0]       req_rank,
  input  logic [IDLE_W-1:0]       req_idle,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic                    cmd_side,
  output logic [ADDR_W-1:0]       cmd_addr,
  output logic [NRANK-1:0]        cmd_cs_n,
  output logic [2:0]              cmd_rcw_n,
  output logic                    err
);

  logic              bad;
  logic [MR_W-1:0]   eff_mr;
  logic [OPC_W-1:0]  eff_opc;
  logic [IDLE_W-1:0] eff_idle;
  logic [ADDR_W-1:0] plain_word, a_word;
  logic              do_swap, accept, start;
  logic              err_q, err_d;

  mrs_req_check #(.IDLE_W(IDLE_W), .TMRD(TMRD)) u_check (
    .kind     (req_kind),
    .mr_in    (req_mr),
    .opc_in   (req_opcode),
    .field    (req_field),
    .idle_in  (req_idle),
    .bad      (bad),
    .mr_out   (eff_mr),
    .opc_out  (eff_opc),
    .idle_out (eff_idle)
  );

  assign plain_word = pack_word(eff_mr, eff_opc);
  assign do_swap    = mirror_en && req_rank[0];

  mrs_addr_mirror u_mirror (
    .swap_en  (do_swap),
    .word_in  (plain_word),
    .word_out (a_word)
  );

  assign accept = req_valid && req_ready;
  assign start  = accept && !bad;
  assign err_d  = accept && bad;

  mrs_issue_fsm #(.NRANK(NRANK), .RANK_W(RANK_W), .IDLE_W(IDLE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .a_word    (a_word),
    .rank      (req_rank),
    .idle      (eff_idle),
    .cmd_ready (cmd_ready),
    .is_idle   (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_side  (cmd_side),
    .cmd_addr  (cmd_addr),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_rcw_n (cmd_rcw_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

endmodule

// File: rtl/mrs_pair_seq_chk.sv
module mrs_pair_seq_chk
  import mrs_seq_pkg::*;
#(
  parameter int NRANK  = 4,
  parameter int RANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_side,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [NRANK-1:0]  cmd_cs_n,
  input logic [2:0]        cmd_rcw_n,
  input logic              err
);

  logic [ADDR_W-1:0] a_seen;
  logic [NRANK-1:0]  cs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen  <= '0;
      cs_seen <= '1;
    end else if (cmd_valid && !cmd_side) begin
      a_seen  <= cmd_addr;
      cs_seen <= cmd_cs_n;
    end
  end

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_no_accept_after_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_side && cmd_ready) |=> !req_ready);

  assert_b_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_side) |-> (cmd_addr == (a_seen ^ INV_MASK)));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cmd_valid && $past(req_valid && req_ready)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_side) && $stable(cmd_cs_n)));

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(~cmd_cs_n) == 1 && cmd_rcw_n == 3'b000));

  assert_cs_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_side) |-> (cmd_cs_n == cs_seen));

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (&cmd_cs_n && cmd_rcw_n == 3'b111));

endmodule

bind mrs_pair_seq mrs_pair_seq_chk #(.NRANK(NRANK), .RANK_W(RANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_side  (cmd_side),
  .cmd_addr  (cmd_addr),
  .cmd_cs_n  (cmd_cs_n),
  .cmd_rcw_n (cmd_rcw_n),
  .err       (err)
);

// File: tb/mrs_pair_seq_test.sv
module mrs_pair_seq_test;

  localparam int NRANK  = 4;
  localparam int RANK_W = 2;
  localparam int IDLE_W = 8;
  localparam int TMRD   = 5;

  logic              clk, rst_n, mirror_en;
  logic              req_valid, req_ready;
  logic [1:0]        req_kind;
  logic [2:0]        req_mr;
  logic [17:0]       req_opcode;
  logic [2:0]        req_field;
  logic [RANK_W-1:0] req_rank;
  logic [IDLE_W-1:0] req_idle;
  logic              cmd_valid, cmd_ready, cmd_side;
  logic [23:0]       cmd_addr;
  logic [NRANK-1:0]  cmd_cs_n;
  logic [2:0]        cmd_rcw_n;
  logic              err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  mrs_pair_seq #(.NRANK(NRANK), .IDLE_W(IDLE_W), .TMRD(TMRD)) uut (
    .clk(clk), .rst_n(rst_n), .mirror_en(mirror_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_mr(req_mr), .req_opcode(req_opcode), .req_field(req_field),
    .req_rank(req_rank), .req_idle(req_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_side(cmd_side),
    .cmd_addr(cmd_addr), .cmd_cs_n(cmd_cs_n), .cmd_rcw_n(cmd_rcw_n), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // model of the word from R2, R4 and R6
  function automatic logic [23:0] model_a(input logic [1:0] kind, input logic [2:0] mr,
      input logic [17:0] opc, input logic [2:0] fld, input logic [1:0] rank, input logic mir);
    logic [23:0] w;
    logic [17:0] o;
    logic [2:0]  m;
    logic        t;
    o = opc; m = mr;
    if (kind == 2'd1) begin o[2] = fld[0]; m = 3'd3; end
    if (kind == 2'd2) begin o[12:11] = fld[1:0]; m = 3'd3; end
    if (kind == 2'd3) begin o[1:0] = fld[1:0]; m = 3'd3; end
    w = '0;
    for (int i = 0; i < 14; i++) w[i] = o[i];
    for (int i = 0; i < 4; i++) w[20+i] = o[14+i];
    w[17] = m[0]; w[18] = m[1]; w[19] = m[2];
    if (mir && rank[0]) begin
      t = w[3];  w[3]  = w[4];  w[4]  = t;
      t = w[5];  w[5]  = w[6];  w[6]  = t;
      t = w[7];  w[7]  = w[8];  w[8]  = t;
      t = w[11]; w[11] = w[13]; w[13] = t;
      t = w[17]; w[17] = w[18]; w[18] = t;
      t = w[19]; w[19] = w[15]; w[15] = t;
    end
    return w;
  endfunction

  // R3 flip list
  function automatic logic [23:0] model_b(input logic [23:0] a);
    logic [23:0] b;
    b = a;
    for (int i = 3; i <= 9; i++) b[i] = ~b[i];
    b[11] = ~b[11]; b[13] = ~b[13]; b[23] = ~b[23];
    b[17] = ~b[17]; b[18] = ~b[18]; b[19] = ~b[19]; b[15] = ~b[15];
    return b;
  endfunction

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  mr;
    logic [17:0] opc;
    logic [1:0]  rank;
    logic [7:0]  idle;
    logic        mir;
    logic [2:0]  fld;
    logic        bad;
    logic        bp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 3'd1, 18'h00A5B, 2'd0, 8'd3, 1'b0, 3'd7, 1'b0, 1'b0},
    '{2'd0, 3'd5, 18'h3FFFF, 2'd1, 8'd2, 1'b1, 3'd0, 1'b0, 1'b1},
    '{2'd0, 3'd2, 18'h01234, 2'd1, 8'd0, 1'b0, 3'd0, 1'b0, 1'b0},
    '{2'd0, 3'd6, 18'h2C0F8, 2'd2, 8'd1, 1'b1, 3'd0, 1'b0, 1'b0},
    '{2'd1, 3'd0, 18'h00400, 2'd3, 8'd9, 1'b1, 3'd1, 1'b0, 1'b0},
    '{2'd1, 3'd0, 18'h00000, 2'd0, 8'd1, 1'b0, 3'd2, 1'b1, 1'b0},
    '{2'd2, 3'd7, 18'h3FFFF, 2'd0, 8'd0, 1'b0, 3'd2, 1'b0, 1'b0},
    '{2'd2, 3'd0, 18'h00000, 2'd1, 8'd1, 1'b1, 3'd3, 1'b1, 1'b0},
    '{2'd3, 3'd1, 18'h15555, 2'd1, 8'd2, 1'b1, 3'd3, 1'b0, 1'b1},
    '{2'd3, 3'd0, 18'h00000, 2'd2, 8'd1, 1'b0, 3'd4, 1'b1, 1'b0},
    '{2'd0, 3'd0, 18'h00000, 2'd0, 8'd0, 1'b0, 3'd0, 1'b0, 1'b0}
  };

  task automatic run_vec(input vec_t v);
    logic [23:0] ea, eb;
    logic [7:0]  eidle;
    logic [3:0]  ecs;
    int          gap;
    ea    = model_a(v.kind, v.mr, v.opc, v.fld, v.rank, v.mir);
    eb    = model_b(ea);
    eidle = (v.kind == 2'd0) ? v.idle : 8'(TMRD);
    ecs   = ~(4'b0001 << v.rank);
    mirror_en  = v.mir;
    req_kind   = v.kind; req_mr = v.mr; req_opcode = v.opc;
    req_field  = v.fld;  req_rank = v.rank; req_idle = v.idle;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (v.bad) begin
      check("R7 err pulse", 32'(err), 32'd1);
      check("R7 no command", 32'(cmd_valid), 32'd0);
      check("R7 ready kept", 32'(req_ready), 32'd1);
      @(negedge clk);
      check("R7 single pulse", 32'(err), 32'd0);
      check("R7 still no command", 32'(cmd_valid), 32'd0);
      return;
    end
    check("R1 A valid", 32'(cmd_valid), 32'd1);
    check("R1 A side", 32'(cmd_side), 32'd0);
    check("R2 R4 R6 A word", 32'(cmd_addr), 32'(ea));
    check("R9 cs A", 32'(cmd_cs_n), 32'(ecs));
    check("R9 rcw A", 32'(cmd_rcw_n), 32'd0);
    check("R7 no err", 32'(err), 32'd0);
    if (v.bp) begin
      @(negedge clk);
      @(negedge clk);
      check("R8 held valid", 32'(cmd_valid), 32'd1);
      check("R8 held word", 32'(cmd_addr), 32'(ea));
      check("R8 held side", 32'(cmd_side), 32'd0);
    end
    cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    gap = 0;
    while (!cmd_valid && gap < 300) begin
      check("R9 deselect in gap", 32'(cmd_cs_n), 32'hF);
      gap++;
      @(negedge clk);
    end
    check("R5 gap after A", 32'(gap), 32'(eidle));
    check("R1 B side", 32'(cmd_side), 32'd1);
    check("R3 B word", 32'(cmd_addr), 32'(eb));
    check("R9 cs B", 32'(cmd_cs_n), 32'(ecs));
    @(posedge clk);
    @(negedge clk);
    gap = 0;
    while (!req_ready && gap < 300) begin
      check("R1 no third command", 32'(cmd_valid), 32'd0);
      gap++;
      @(negedge clk);
    end
    check("R5 gap after B", 32'(gap), 32'(eidle));
    check("R1 idle after pair", 32'(cmd_valid), 32'd0);
    cmd_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mirror_en = 1'b0; req_valid = 1'b0; cmd_ready = 1'b0;
    req_kind = '0; req_mr = '0; req_opcode = '0; req_field = '0;
    req_rank = '0; req_idle = '0;
    repeat (3) @(negedge clk);
    check("R10 ready", 32'(req_ready), 32'd1);
    check("R10 valid", 32'(cmd_valid), 32'd0);
    check("R10 err", 32'(err), 32'd0);
    check("R10 cs", 32'(cmd_cs_n), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 32'(cmd_valid), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // reset in the middle of a pair returns to the reset state
    mirror_en = 1'b0; req_kind = 2'd0; req_mr = 3'd4; req_opcode = 18'h0F0F0;
    req_rank = 2'd3; req_idle = 8'd4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 A pending", 32'(cmd_valid), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid-pair reset valid", 32'(cmd_valid), 32'd0);
    check("R10 mid-pair reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 nothing after reset", 32'(cmd_valid), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule